// File: doc/BRIEF.md
# ATAPI Packet Phase Sequencer

This block is the host-side control state machine for ATAPI packet commands. It follows one command per attached drive from the moment it is issued until the drive reports final status. On every device interrupt it decodes three bits into a 3-bit phase event. The BSY, DRQ and error bits come from the status register, and the IO and CoD bits come from the interrupt-reason register. Two lookup tables, indexed by the current state and the event, then give the action to take and the next state.

Each action comes out as a one-cycle strobe to the surrounding blocks. There are strobes to push the command packet, move one PIO burst in either direction, start or stop the DMA engine, and finish the command. The command's outcome is reported alongside: the error flag, the latched status and error bytes, and whether the residual count may be cleared.

The tables tolerate common drive misbehaviour. A status phase reported without CoD still finishes the command. DRQ that drops between data bursts is tolerated. Both cases are recorded in sticky per-drive flags. A start request is accepted only while the addressed drive is idle. Every register change is visible one clock after the inputs that cause it.

Top module: `atapi_phase_seq`

## Requirements
- R1: The phase event is {IO, CoD, DRQ}, with IO = irq_reason_i[1], CoD = irq_reason_i[0] and DRQ = irq_stat_i[3]. The state codes on drv_state_o (3 bits per drive, drive d at bits 3d+2:3d) are Idle=0, Cmd=1, Cdb=2, DataIn=3, DataOut=4 and DmaActive=5.
- R2: A start request to an Idle drive pulses start_ack_o and moves that drive to Cmd, latching its DMA, read and write attributes. A start request to a drive in any other state pulses start_busy_o and leaves the drive unchanged.
- R3: In Cmd, event 3 pulses act_cdb_o and moves to Cdb, and event 6 finishes the command and moves to Idle. Every other event gives no strobe and leaves the state as it is.
- R4: In Cdb, event 1 moves to DataOut with a PIO-out action, and event 5 moves to DataIn with a PIO-in action. Events 2 and 3 give no strobe and stay in Cdb.
- R5: When the command-packet action happens on a DMA command, act_dma_start_o pulses together with act_cdb_o and the drive goes to DmaActive.
- R6: Event 6 finishes the command from every state except Idle. Event 0 finishes it from Cdb, DataIn, DataOut and DmaActive, and also sets that drive's sticky status_warn_o bit. Finishing pulses act_done_o and returns the drive to Idle.
- R7: Event 2 in DataIn or DataOut, and event 4 in Cdb, DataIn or DataOut, keep the state and set that drive's sticky bogus_drq_o bit. In DataIn, DataOut and Cdb, any event with no defined meaning pulses unknown_o and keeps the state. These are event 7 in all three, events 1 and 3 in DataIn, and events 3 and 5 in DataOut.
- R8: Any interrupt to a drive in DmaActive pulses act_dma_stop_o, busy or not. Events other than 0 and 6 then pulse unknown_o and keep DmaActive.
- R9: An interrupt with BSY (irq_stat_i[7]) set changes no state and gives no strobe other than the DMA stop of R8.
- R10: On finishing, done_err_o is DF (bit 5) OR ERR (bit 0) of the status byte. Only an erroneous finish loads stat_latch_o and err_latch_o. resid_zero_o pulses when the finish comes from DmaActive and dma_xfer_err_i is low.
- R11: A PIO-in action on a command without the read attribute, or a PIO-out action on one without the write attribute, pulses proto_err_o and no data strobe. On a DMA command, a correctly directed data action gives no data strobe.
- R12: An interrupt to an Idle drive gives no strobe and leaves it Idle.
- R13: A synchronous active-low reset returns every drive to Idle and clears the sticky flags and latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to issue a command |
| start_drv | input | DRV_W | Drive addressed by the start request |
| start_dma | input | 1 | Command moves data by DMA |
| start_rd | input | 1 | Command reads from the drive |
| start_wr | input | 1 | Command writes to the drive |
| irq_valid | input | 1 | A device interrupt is presented |
| irq_drv | input | DRV_W | Drive raising the interrupt |
| irq_stat_i | input | 8 | Status register byte |
| irq_reason_i | input | 2 | Interrupt reason {IO, CoD} |
| irq_error_i | input | 8 | Error register byte |
| dma_xfer_err_i | input | 1 | DMA engine reported a transfer error |
| start_ack_o | output | 1 | Start accepted |
| start_busy_o | output | 1 | Start refused |
| evt_drv_o | output | DRV_W | Drive the interrupt strobes refer to |
| act_cdb_o | output | 1 | Push the command packet |
| act_pio_in_o | output | 1 | Move one PIO burst from the drive |
| act_pio_out_o | output | 1 | Move one PIO burst to the drive |
| act_dma_start_o | output | 1 | Start the DMA engine |
| act_dma_stop_o | output | 1 | Stop the DMA engine |
| act_done_o | output | 1 | Command finished |
| done_err_o | output | 1 | Finished command failed |
| resid_zero_o | output | 1 | Residual count may be cleared |
| proto_err_o | output | 1 | Data phase against command direction |
| unknown_o | output | 1 | Event undefined in this state |
| stat_latch_o | output | 8 | Status byte of last failed command |
| err_latch_o | output | 8 | Error byte of last failed command |
| bogus_drq_o | output | NUM_DRV | Sticky DRQ-dropped flag per drive |
| status_warn_o | output | NUM_DRV | Sticky missing-CoD flag per drive |
| drv_state_o | output | 3*NUM_DRV | State of every drive |

## Verification
Directed sequences take one drive through a PIO read, a PIO write with the wrong direction, and a DMA write. These show that each table row gives the right strobe and next state, and that a BSY interrupt and an Idle interrupt are both inert. Random streams then spread all eight event codes over both drives. They add random BSY, DF, ERR and DMA transfer-error bits, and put random garbage in the status bits that are not decoded. This separates a correct table entry from a neighbouring one, and separates the latched completion values from the values a non-failing finish must leave alone. A mid-run reset shows that the sticky flags and states are cleared.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_CDB  = 3'd2,
        ST_DIN  = 3'd3,
        ST_DOUT = 3'd4,
        ST_DMA  = 3'd5
    } phase_st_e;

    typedef enum logic [2:0] {
        EV_BAD0     = 3'd0,
        EV_TO_DEV   = 3'd1,
        EV_IDLE     = 3'd2,
        EV_PKT      = 3'd3,
        EV_BAD4     = 3'd4,
        EV_FROM_DEV = 3'd5,
        EV_STATUS   = 3'd6,
        EV_RSVD     = 3'd7
    } phase_ev_e;

    typedef enum logic [2:0] {
        AC_NONE,
        AC_CDB,
        AC_IN,
        AC_OUT,
        AC_DRQ_LOST,
        AC_FINISH,
        AC_FINISH_QK,
        AC_UNKNOWN
    } act_e;

    localparam int BIT_BSY = 7;
    localparam int BIT_DF  = 5;
    localparam int BIT_DRQ = 3;
    localparam int BIT_ERR = 0;
    localparam int BIT_COD = 0;
    localparam int BIT_IO  = 1;

    typedef struct packed {
        phase_st_e st;
        logic      dma;
        logic      rd;
        logic      wr;
        logic      bogus;
        logic      warn;
    } drv_ctx_t;

endpackage

// File: rtl/atapi_evt_enc.sv
module atapi_evt_enc
    import atapi_seq_pkg::*;
(
    input  logic      bsy_i,
    input  logic      drq_i,
    input  logic      io_i,
    input  logic      cod_i,
    output phase_ev_e ev_o,
    output logic      busy_o
);
    always_comb begin
        ev_o   = phase_ev_e'({io_i, cod_i, drq_i});
        busy_o = bsy_i;
    end
endmodule

// File: rtl/atapi_phase_table.sv
module atapi_phase_table
    import atapi_seq_pkg::*;
(
    input  phase_st_e st_i,
    input  phase_ev_e ev_i,
    output act_e      act_o,
    output phase_st_e nxt_o
);
    always_comb begin
        act_o = AC_NONE;
        nxt_o = st_i;
        case (st_i)
            ST_IDLE: begin
                act_o = AC_NONE;
            end
            ST_CMD: begin
                if (ev_i == EV_PKT) begin
                    act_o = AC_CDB;
                    nxt_o = ST_CDB;
                end else if (ev_i == EV_STATUS) begin
                    act_o = AC_FINISH;
                    nxt_o = ST_IDLE;
                end
            end
            ST_CDB: begin
                case (ev_i)
                    EV_BAD0:     begin act_o = AC_FINISH_QK; nxt_o = ST_IDLE; end
                    EV_TO_DEV:   begin act_o = AC_OUT;       nxt_o = ST_DOUT; end
                    EV_IDLE,
                    EV_PKT:      act_o = AC_NONE;
                    EV_BAD4:     act_o = AC_DRQ_LOST;
                    EV_FROM_DEV: begin act_o = AC_IN;        nxt_o = ST_DIN;  end
                    EV_STATUS:   begin act_o = AC_FINISH;    nxt_o = ST_IDLE; end
                    default:     act_o = AC_UNKNOWN;
                endcase
            end
            ST_DIN: begin
                case (ev_i)
                    EV_BAD0:     begin act_o = AC_FINISH_QK; nxt_o = ST_IDLE; end
                    EV_IDLE,
                    EV_BAD4:     act_o = AC_DRQ_LOST;
                    EV_FROM_DEV: act_o = AC_IN;
                    EV_STATUS:   begin act_o = AC_FINISH;    nxt_o = ST_IDLE; end
                    default:     act_o = AC_UNKNOWN;
                endcase
            end
            ST_DOUT: begin
                case (ev_i)
                    EV_BAD0:     begin act_o = AC_FINISH_QK; nxt_o = ST_IDLE; end
                    EV_IDLE,
                    EV_BAD4:     act_o = AC_DRQ_LOST;
                    EV_TO_DEV:   act_o = AC_OUT;
                    EV_STATUS:   begin act_o = AC_FINISH;    nxt_o = ST_IDLE; end
                    default:     act_o = AC_UNKNOWN;
                endcase
            end
            ST_DMA: begin
                case (ev_i)
                    EV_BAD0:     begin act_o = AC_FINISH_QK; nxt_o = ST_IDLE; end
                    EV_STATUS:   begin act_o = AC_FINISH;    nxt_o = ST_IDLE; end
                    default:     act_o = AC_UNKNOWN;
                endcase
            end
            default: begin
                act_o = AC_NONE;
                nxt_o = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/atapi_cmpl_eval.sv
module atapi_cmpl_eval (
    input  logic df_i,
    input  logic err_i,
    input  logic from_dma_i,
    input  logic xfer_err_i,
    output logic fail_o,
    output logic resid_zero_o
);
    always_comb begin
        fail_o       = df_i | err_i;
        resid_zero_o = from_dma_i & ~xfer_err_i;
    end
endmodule

// File: rtl/atapi_phase_seq.sv
module atapi_phase_seq
    import atapi_seq_pkg::*;
#(
    parameter int NUM_DRV = 2,
    localparam int DRV_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_req,
    input  logic [DRV_W-1:0]     start_drv,
    input  logic                 start_dma,
    input  logic                 start_rd,
    input  logic                 start_wr,
    input  logic                 irq_valid,
    input  logic [DRV_W-1:0]     irq_drv,
    input  logic [7:0]           irq_stat_i,
    input  logic [1:0]           irq_reason_i,
    input  logic [7:0]           irq_error_i,
    input  logic                 dma_xfer_err_i,
    output logic                 start_ack_o,
    output logic                 start_busy_o,
    output logic [DRV_W-1:0]     evt_drv_o,
    output logic                 act_cdb_o,
    output logic                 act_pio_in_o,
    output logic                 act_pio_out_o,
    output logic                 act_dma_start_o,
    output logic                 act_dma_stop_o,
    output logic                 act_done_o,
    output logic                 done_err_o,
    output logic                 resid_zero_o,
    output logic                 proto_err_o,
    output logic                 unknown_o,
    output logic [7:0]           stat_latch_o,
    output logic [7:0]           err_latch_o,
    output logic [NUM_DRV-1:0]   bogus_drq_o,
    output logic [NUM_DRV-1:0]   status_warn_o,
    output logic [3*NUM_DRV-1:0] drv_state_o
);

    typedef struct packed {
        drv_ctx_t [NUM_DRV-1:0] ctx;
        logic                   ack;
        logic                   busy;
        logic [DRV_W-1:0]       evt_drv;
        logic                   cdb;
        logic                   pin;
        logic                   pout;
        logic                   dstart;
        logic                   dstop;
        logic                   done;
        logic                   derr;
        logic                   rzero;
        logic                   perr;
        logic                   unk;
        logic [7:0]             slat;
        logic [7:0]             elat;
    } seq_regs_t;

    seq_regs_t d, q;

    logic      irq_hit;
    logic      start_ok_drv;
    drv_ctx_t  cur_ctx;
    drv_ctx_t  upd_ctx;
    drv_ctx_t  tgt_ctx;
    phase_ev_e ev;
    logic      ev_busy;
    act_e      tbl_act;
    phase_st_e tbl_nxt;
    logic      cm_fail;
    logic      cm_rzero;

    // Pick the context of the interrupting drive
    always_comb begin
        irq_hit      = irq_valid && (int'(irq_drv) < NUM_DRV);
        start_ok_drv = int'(start_drv) < NUM_DRV;
        cur_ctx      = irq_hit ? q.ctx[irq_drv] : '0;
        tgt_ctx      = start_ok_drv ? q.ctx[start_drv] : '0;
    end

    atapi_evt_enc u_enc (
        .bsy_i  (irq_stat_i[BIT_BSY]),
        .drq_i  (irq_stat_i[BIT_DRQ]),
        .io_i   (irq_reason_i[BIT_IO]),
        .cod_i  (irq_reason_i[BIT_COD]),
        .ev_o   (ev),
        .busy_o (ev_busy)
    );

    atapi_phase_table u_tbl (
        .st_i  (cur_ctx.st),
        .ev_i  (ev),
        .act_o (tbl_act),
        .nxt_o (tbl_nxt)
    );

    atapi_cmpl_eval u_cmpl (
        .df_i         (irq_stat_i[BIT_DF]),
        .err_i        (irq_stat_i[BIT_ERR]),
        .from_dma_i   (cur_ctx.st == ST_DMA),
        .xfer_err_i   (dma_xfer_err_i),
        .fail_o       (cm_fail),
        .resid_zero_o (cm_rzero)
    );

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        d.busy   = 1'b0;
        d.cdb    = 1'b0;
        d.pin    = 1'b0;
        d.pout   = 1'b0;
        d.dstart = 1'b0;
        d.dstop  = 1'b0;
        d.done   = 1'b0;
        d.derr   = 1'b0;
        d.rzero  = 1'b0;
        d.perr   = 1'b0;
        d.unk    = 1'b0;
        upd_ctx  = cur_ctx;

        if (irq_hit) begin
            d.evt_drv = irq_drv;
            // the DMA engine is halted before anything else is looked at
            if (cur_ctx.st == ST_DMA) begin
                d.dstop = 1'b1;
            end
            if (!ev_busy) begin
                upd_ctx.st = tbl_nxt;
                case (tbl_act)
                    AC_CDB: begin
                        d.cdb = 1'b1;
                        if (cur_ctx.dma) begin
                            d.dstart   = 1'b1;
                            upd_ctx.st = ST_DMA;
                        end
                    end
                    AC_IN: begin
                        if (!cur_ctx.rd) begin
                            d.perr = 1'b1;
                        end else if (!cur_ctx.dma) begin
                            d.pin = 1'b1;
                        end
                    end
                    AC_OUT: begin
                        if (!cur_ctx.wr) begin
                            d.perr = 1'b1;
                        end else if (!cur_ctx.dma) begin
                            d.pout = 1'b1;
                        end
                    end
                    AC_DRQ_LOST: begin
                        upd_ctx.bogus = 1'b1;
                    end
                    AC_FINISH,
                    AC_FINISH_QK: begin
                        d.done  = 1'b1;
                        d.derr  = cm_fail;
                        d.rzero = cm_rzero;
                        if (cm_fail) begin
                            d.slat = irq_stat_i;
                            d.elat = irq_error_i;
                        end
                        if (tbl_act == AC_FINISH_QK) begin
                            upd_ctx.warn = 1'b1;
                        end
                    end
                    AC_UNKNOWN: begin
                        d.unk = 1'b1;
                    end
                    default: begin
                        d.unk = 1'b0;
                    end
                endcase
                d.ctx[irq_drv] = upd_ctx;
            end
        end

        if (start_req) begin
            if (!start_ok_drv || (irq_hit && (start_drv == irq_drv)) ||
                (tgt_ctx.st != ST_IDLE)) begin
                d.busy = 1'b1;
            end else begin
                d.ack = 1'b1;
                d.ctx[start_drv] = '{st:    ST_CMD,
                                     dma:   start_dma,
                                     rd:    start_rd,
                                     wr:    start_wr,
                                     bogus: tgt_ctx.bogus,
                                     warn:  tgt_ctx.warn};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign start_ack_o     = q.ack;
    assign start_busy_o    = q.busy;
    assign evt_drv_o       = q.evt_drv;
    assign act_cdb_o       = q.cdb;
    assign act_pio_in_o    = q.pin;
    assign act_pio_out_o   = q.pout;
    assign act_dma_start_o = q.dstart;
    assign act_dma_stop_o  = q.dstop;
    assign act_done_o      = q.done;
    assign done_err_o      = q.derr;
    assign resid_zero_o    = q.rzero;
    assign proto_err_o     = q.perr;
    assign unknown_o       = q.unk;
    assign stat_latch_o    = q.slat;
    assign err_latch_o     = q.elat;

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv_out
        assign drv_state_o[3*g +: 3] = q.ctx[g].st;
        assign bogus_drq_o[g]        = q.ctx[g].bogus;
        assign status_warn_o[g]      = q.ctx[g].warn;
    end

endmodule

// File: rtl/atapi_phase_seq_chk.sv
module atapi_phase_seq_chk #(
    parameter int NUM_DRV = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_ack_o,
    input logic               start_busy_o,
    input logic               act_cdb_o,
    input logic               act_pio_in_o,
    input logic               act_pio_out_o,
    input logic               act_dma_start_o,
    input logic               act_done_o,
    input logic               done_err_o,
    input logic               resid_zero_o,
    input logic               proto_err_o,
    input logic               unknown_o,
    input logic [NUM_DRV-1:0] bogus_drq_o,
    input logic [NUM_DRV-1:0] status_warn_o
);
    p_ack_or_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_ack_o && start_busy_o));

    // one table action per interrupt (R3, R4, R11)
    p_single_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_cdb_o, act_pio_in_o, act_pio_out_o, act_done_o,
                  unknown_o, proto_err_o}));

    p_dma_with_cdb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_dma_start_o |-> act_cdb_o);

    p_resid_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (resid_zero_o || done_err_o) |-> act_done_o);

    p_bogus_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(bogus_drq_o) & ~bogus_drq_o) == '0));

    p_warn_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status_warn_o) & ~status_warn_o) == '0));
endmodule

bind atapi_phase_seq atapi_phase_seq_chk #(.NUM_DRV(NUM_DRV)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_ack_o     (start_ack_o),
    .start_busy_o    (start_busy_o),
    .act_cdb_o       (act_cdb_o),
    .act_pio_in_o    (act_pio_in_o),
    .act_pio_out_o   (act_pio_out_o),
    .act_dma_start_o (act_dma_start_o),
    .act_done_o      (act_done_o),
    .done_err_o      (done_err_o),
    .resid_zero_o    (resid_zero_o),
    .proto_err_o     (proto_err_o),
    .unknown_o       (unknown_o),
    .bogus_drq_o     (bogus_drq_o),
    .status_warn_o   (status_warn_o)
);

// File: tb/atapi_phase_seq_test.sv
`timescale 1ns/1ps
module atapi_phase_seq_test;
    localparam int ND = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 0, start_dma = 0, start_rd = 0, start_wr = 0;
    logic [0:0] start_drv = '0, irq_drv = '0;
    logic       irq_valid = 0, dma_xfer_err_i = 0;
    logic [7:0] irq_stat_i = '0, irq_error_i = '0;
    logic [1:0] irq_reason_i = '0;
    logic       start_ack_o, start_busy_o, act_cdb_o, act_pio_in_o, act_pio_out_o;
    logic       act_dma_start_o, act_dma_stop_o, act_done_o, done_err_o;
    logic       resid_zero_o, proto_err_o, unknown_o;
    logic [0:0] evt_drv_o;
    logic [7:0] stat_latch_o, err_latch_o;
    logic [ND-1:0] bogus_drq_o, status_warn_o;
    logic [3*ND-1:0] drv_state_o;

    always #2.5 clk = ~clk;

    atapi_phase_seq #(.NUM_DRV(ND)) uut (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int       m_st[ND];
    bit       m_dma[ND], m_rd[ND], m_wr[ND], m_bog[ND], m_warn[ND];
    bit [7:0] m_slat, m_elat;

    // action codes used by the bench model
    localparam int A_NONE = 0, A_CDB = 1, A_IN = 2, A_OUT = 3,
                   A_DRQ = 4, A_FIN = 5, A_FINQ = 6, A_UNK = 7;

    task automatic chk(string req, string what, longint got, longint exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic void tbl(int st, int ev, output int act, output int nxt);
        act = A_NONE;
        nxt = st;
        case (st)
            1: if (ev == 3) begin act = A_CDB; nxt = 2; end
               else if (ev == 6) begin act = A_FIN; nxt = 0; end
            2: case (ev)
                   0: begin act = A_FINQ; nxt = 0; end
                   1: begin act = A_OUT; nxt = 4; end
                   4: act = A_DRQ;
                   5: begin act = A_IN; nxt = 3; end
                   6: begin act = A_FIN; nxt = 0; end
                   7: act = A_UNK;
                   default: act = A_NONE;
               endcase
            3: case (ev)
                   0: begin act = A_FINQ; nxt = 0; end
                   2, 4: act = A_DRQ;
                   5: act = A_IN;
                   6: begin act = A_FIN; nxt = 0; end
                   default: act = A_UNK;
               endcase
            4: case (ev)
                   0: begin act = A_FINQ; nxt = 0; end
                   2, 4: act = A_DRQ;
                   1: act = A_OUT;
                   6: begin act = A_FIN; nxt = 0; end
                   default: act = A_UNK;
               endcase
            5: case (ev)
                   0: begin act = A_FINQ; nxt = 0; end
                   6: begin act = A_FIN; nxt = 0; end
                   default: act = A_UNK;
               endcase
            default: act = A_NONE;
        endcase
    endfunction

    function automatic string tag_of(int st);
        case (st)
            0: return "R12";
            1: return "R3";
            2: return "R4";
            5: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check_ctx(string req);
        for (int i = 0; i < ND; i++) begin
            chk(req, "state", drv_state_o[3*i +: 3], m_st[i]);
            chk("R7", "bogus flag", bogus_drq_o[i], m_bog[i]);
            chk("R6", "warn flag", status_warn_o[i], m_warn[i]);
        end
        chk("R10", "latches", {stat_latch_o, err_latch_o}, {m_slat, m_elat});
    endtask

    task automatic do_start(int d, bit dma, bit rd, bit wr);
        bit acc;
        start_req = 1; start_drv = d[0:0]; start_dma = dma; start_rd = rd; start_wr = wr;
        acc = (m_st[d] == 0);
        if (acc) begin
            m_st[d] = 1; m_dma[d] = dma; m_rd[d] = rd; m_wr[d] = wr;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R2", "ack/busy", {start_ack_o, start_busy_o}, {acc, !acc});
        chk("R2", "strobes idle", {act_cdb_o, act_done_o, unknown_o}, 0);
        check_ctx("R2");
        start_req = 0;
    endtask

    task automatic do_irq(int d, int ev, bit bsy, bit df, bit er, bit xerr);
        int act, nxt, old;
        bit [9:0] e;
        bit [7:0] s, ee;
        string tg;
        s = 8'($urandom);
        s[7] = bsy; s[5] = df; s[3] = ev[0]; s[0] = er;
        ee = 8'($urandom);
        irq_valid = 1; irq_drv = d[0:0]; irq_stat_i = s; irq_error_i = ee;
        irq_reason_i = {ev[2], ev[1]}; dma_xfer_err_i = xerr;
        old = m_st[d];
        e = '0;
        // order: cdb pin pout dstart dstop done derr rzero perr unk
        e[5] = (old == 5);
        tg = bsy ? "R9" : tag_of(old);
        if (!bsy) begin
            tbl(old, ev, act, nxt);
            m_st[d] = nxt;
            case (act)
                A_CDB: begin
                    e[9] = 1;
                    if (m_dma[d]) begin e[6] = 1; m_st[d] = 5; tg = "R5"; end
                end
                A_IN:  if (!m_rd[d]) begin e[1] = 1; tg = "R11"; end
                       else if (!m_dma[d]) e[8] = 1;
                A_OUT: if (!m_wr[d]) begin e[1] = 1; tg = "R11"; end
                       else if (!m_dma[d]) e[7] = 1;
                A_DRQ: m_bog[d] = 1;
                A_FIN, A_FINQ: begin
                    e[4] = 1; e[3] = df | er; e[2] = (old == 5) && !xerr;
                    if (df | er) begin m_slat = s; m_elat = ee; end
                    if (act == A_FINQ) begin m_warn[d] = 1; tg = "R6"; end
                end
                A_UNK: e[0] = 1;
                default: e = e;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk(tg, $sformatf("strobes st=%0d ev=%0d", old, ev),
            {act_cdb_o, act_pio_in_o, act_pio_out_o, act_dma_start_o, act_dma_stop_o,
             act_done_o, done_err_o, resid_zero_o, proto_err_o, unknown_o}, e);
        chk("R1", "event drive", evt_drv_o, d);
        check_ctx(tg);
        irq_valid = 0; dma_xfer_err_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < ND; i++) begin
            m_st[i] = 0; m_bog[i] = 0; m_warn[i] = 0; m_dma[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
        end
        m_slat = 0; m_elat = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        check_ctx("R13");
        chk("R13", "strobes after reset", {start_ack_o, act_done_o, unknown_o}, 0);

        // idle drive ignores interrupts
        do_irq(0, 6, 0, 0, 0, 0);
        // PIO read flow on drive 0
        do_start(0, 0, 1, 0);
        do_start(0, 0, 1, 0);               // refused: R2
        do_irq(0, 5, 0, 0, 0, 0);           // Cmd ignores data event: R3
        do_irq(0, 3, 0, 0, 0, 0);           // send packet: R3
        do_irq(0, 5, 1, 0, 0, 0);           // BSY: R9
        do_irq(0, 5, 0, 0, 0, 0);           // PIO in: R4
        do_irq(0, 2, 0, 0, 0, 0);           // DRQ dropped: R7
        do_irq(0, 1, 0, 0, 0, 0);           // wrong direction: R7
        do_irq(0, 6, 0, 0, 1, 0);           // error finish: R10
        chk("R10", "status latch", stat_latch_o[0], 1);
        // DMA write flow on drive 1
        do_start(1, 1, 0, 1);
        do_irq(1, 3, 0, 0, 0, 0);           // R5
        chk("R5", "dma state", drv_state_o[5:3], 5);
        do_irq(1, 1, 1, 0, 0, 0);           // busy in DMA: R8 stop only
        do_irq(1, 1, 0, 0, 0, 0);           // R8 unknown
        do_irq(1, 0, 0, 0, 0, 0);           // missing CoD finish: R6
        chk("R6", "warn drive1", status_warn_o[1], 1);
        // direction mismatch on drive 0
        do_start(0, 0, 1, 0);
        do_irq(0, 3, 0, 0, 0, 0);
        do_irq(0, 1, 0, 0, 0, 0);           // R11
        chk("R11", "state after mismatch", drv_state_o[2:0], 4);
        do_irq(0, 6, 0, 1, 0, 0);

        for (int k = 0; k < 4000; k++) begin
            int d;
            d = int'($urandom_range(0, ND - 1));
            if ($urandom_range(0, 3) == 0) begin
                do_start(d, 1'($urandom), 1'($urandom), 1'($urandom));
            end else begin
                do_irq(d, int'($urandom_range(0, 7)), ($urandom_range(0, 7) == 0),
                       ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
                       ($urandom_range(0, 3) == 0));
            end
        end

        do_reset();
        check_ctx("R13");
        do_start(1, 0, 1, 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule